// File: doc/BRIEF.md
# Compressed Stack Push/Pop Expander

This block turns one 16-bit compressed stack instruction (push, pop, pop-and-return, or pop-zero-and-return) into a sequence of micro-operations for a 32- or 64-bit integer core. It decodes the instruction, checks that it is legal, and works out the stack frame size. It then issues one single-register load or store per saved register through a valid/ready port. After the transfers it issues one stack pointer update, followed by the tail actions of the variant.

The core pulses `start_i` with the instruction word while the block is idle, and picks the register width with `xlen64_i`. Memory offsets are relative to the stack pointer value before the instruction. The stack pointer adjustment is a signed byte count that the core adds to the stack pointer. The register file, the memory system and any trap handling stay outside the block.

Top module: `pp_expander`

## Requirements
- R1: An instruction is accepted only if bits [1:0] are 2'b10, bits [15:11] are 5'b10111 and bit 8 is 0. Bits [10:9] select the variant: 0 push, 1 pop, 2 pop-zero-return, 3 pop-return. Any other word raises `illegal_o` and starts no operation.
- R2: A register-list field (bits [7:4]) below 4 raises `illegal_o` for exactly one cycle, in the cycle after `start_i`. No memory, stack or done activity follows.
- R3: List code r gives a register count of r-3 for codes 4..14, and 13 for code 15. The registers are issued in this order: x1, x8, x9, then x18, x19, … up to x27.
- R4: The adjustment magnitude is the count × B bytes (B = 4, or 8 when `xlen64_i` is 1), rounded up to a multiple of 16. The stack immediate (bits [3:2]) × 16 is then added.
- R5: Push issues stores. Step i (from 0) goes to offset -(i+1)×B, and `sp_adj_o` is the negated magnitude.
- R6: The pop variants issue loads. Step i reads from offset M-(i+1)×B, where M is the magnitude, and `sp_adj_o` is +M.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, the request holds: valid, register, offset and direction do not change.
- R8: `sp_we_o` pulses for exactly one cycle, in the cycle after the last transfer is accepted.
- R9: The pop-zero-return variant pulses `a0_zero_o` in the cycle after `sp_we_o`. Both return variants then pulse `ret_req_o` for one cycle, and `done_o` follows in the next cycle.
- R10: `done_o` is high for exactly one cycle at the end of every legal instruction, and the block is idle in the following cycle. At most one of the valid, stack-write, zero, return and done outputs is high in any cycle.
- R11: `start_i` is ignored while `busy_o` is high. The sequence in progress goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Instruction present (sampled while idle) |
| instr_i | input | 16 | Compressed instruction word |
| xlen64_i | input | 1 | 1 = 8-byte registers, 0 = 4-byte registers |
| mem_ready_i | input | 1 | Load/store port accepts the current request |
| busy_o | output | 1 | A sequence is in progress |
| illegal_o | output | 1 | One-cycle pulse for a rejected instruction |
| mem_valid_o | output | 1 | Load/store request valid |
| mem_store_o | output | 1 | 1 = store, 0 = load |
| mem_reg_o | output | 5 | Register index of the request |
| mem_off_o | output | ADJ_W | Signed byte offset from the old stack pointer |
| sp_we_o | output | 1 | Stack pointer update pulse |
| sp_adj_o | output | ADJ_W | Signed stack pointer adjustment |
| a0_zero_o | output | 1 | Write zero to x10 |
| ret_req_o | output | 1 | Jump to the restored return address |
| done_o | output | 1 | Sequence finished |

## Verification
The bench builds the block with its default parameters: 16-byte alignment (ALIGN_LG = 4) and 12-bit signed offsets and adjustments. Those values cover the largest frame (13 eight-byte slots plus 48, which is 160 bytes) and the most negative store offset. Within that build, `xlen64_i` reaches both register widths at run time. Directed sweeps cover every list code with every variant and both widths. Random runs add stalls on the ready line, extra start pulses while busy, and corrupted opcodes.

// File: rtl/pp_pkg.sv
// Package: shared types for the push/pop expander.
// Assumes: variant codes equal instruction bits [10:9].
package pp_pkg;
    typedef enum logic [1:0] {
        VAR_PUSH    = 2'd0,
        VAR_POP     = 2'd1,
        VAR_POPRETZ = 2'd2,
        VAR_POPRET  = 2'd3
    } variant_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MEM  = 3'd1,
        ST_SPW  = 3'd2,
        ST_ZERO = 3'd3,
        ST_RET  = 3'd4,
        ST_DONE = 3'd5
    } state_e;

    localparam int REG_W     = 5;
    localparam int STEP_W    = 4;
    localparam int MAX_REGS  = 13;
    localparam logic [4:0] OP_HIGH = 5'b10111;
    localparam logic [1:0] OP_QUAD = 2'b10;
endpackage

// File: rtl/pp_decode.sv
// Module: pp_decode
// Checks the opcode fields and the register-list code, and computes the
// register count, the slot size and the rounded stack adjustment magnitude.
// Assumes: ALIGN is a power of two; ADJ_W holds the largest frame.
module pp_decode
    import pp_pkg::*;
#(
    parameter int ALIGN_LG = 4,
    parameter int ADJ_W    = 12
) (
    input  logic [15:0]       instr_i,
    input  logic              xlen64_i,
    output logic              legal_o,
    output variant_e          variant_o,
    output logic [STEP_W-1:0] count_o,
    output logic [ADJ_W-1:0]  slot_o,
    output logic [ADJ_W-1:0]  adj_o
);
    localparam int ALIGN = 1 << ALIGN_LG;

    logic [3:0]       rlist;
    logic [1:0]       spimm;
    logic             op_ok;
    logic             list_ok;
    logic [ADJ_W-1:0] raw_bytes;
    logic [ADJ_W-1:0] rounded;

    // Field split and legality of the opcode and the register-list code.
    always_comb begin
        rlist   = instr_i[7:4];
        spimm   = instr_i[3:2];
        op_ok   = (instr_i[1:0] == OP_QUAD) && (instr_i[15:11] == OP_HIGH)
                  && !instr_i[8];
        list_ok = (rlist >= 4'd4);
        legal_o = op_ok && list_ok;
        variant_o = variant_e'(instr_i[10:9]);
    end

    // Register count: the last code adds two registers at once.
    always_comb begin
        if (rlist == 4'hF)
            count_o = STEP_W'(MAX_REGS);
        else
            count_o = rlist - 4'd3;
    end

    // Frame size: count times slot bytes, aligned up, plus the extra immediate.
    always_comb begin
        slot_o    = xlen64_i ? ADJ_W'(8) : ADJ_W'(4);
        raw_bytes = ADJ_W'(count_o) * slot_o;
        rounded   = ((raw_bytes + ADJ_W'(ALIGN - 1)) >> ALIGN_LG) << ALIGN_LG;
        adj_o     = rounded + (ADJ_W'(spimm) << ALIGN_LG);
    end
endmodule

// File: rtl/pp_regmap.sv
// Module: pp_regmap
// Maps a step number to the register index: x1, then x8, x9, then a
// contiguous run starting at HIGH_BASE. Steps past the list give 0.
// Assumes: step values come from pp_seq and stay below the list length.
module pp_regmap
    import pp_pkg::*;
#(
    parameter int FIRST_S   = 8,
    parameter int HIGH_BASE = 18
) (
    input  logic [STEP_W-1:0] step_i,
    output logic [REG_W-1:0]  reg_o
);
    localparam int DEPTH = 1 << STEP_W;

    logic [REG_W-1:0] lut [DEPTH];

    // One table entry per step position, built at elaboration.
    for (genvar g = 0; g < DEPTH; g++) begin : g_map
        if (g == 0) begin : g_ra
            assign lut[g] = REG_W'(1);
        end else if (g < 3) begin : g_low
            assign lut[g] = REG_W'(FIRST_S + g - 1);
        end else if (g < MAX_REGS) begin : g_high
            assign lut[g] = REG_W'(HIGH_BASE + g - 3);
        end else begin : g_none
            assign lut[g] = '0;
        end
    end

    assign reg_o = lut[step_i];
endmodule

// File: rtl/pp_seq.sv
// Module: pp_seq
// Step sequencer: latches the decoded instruction, runs the load/store
// steps with a valid/ready handshake, then the stack update and the tail actions.
// Assumes: decode inputs are valid whenever start_i is high.
module pp_seq
    import pp_pkg::*;
#(
    parameter int ADJ_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              legal_i,
    input  variant_e          variant_i,
    input  logic [STEP_W-1:0] count_i,
    input  logic [ADJ_W-1:0]  slot_i,
    input  logic [ADJ_W-1:0]  adj_i,
    input  logic              mem_ready_i,
    output logic              busy_o,
    output logic              illegal_o,
    output logic              mem_valid_o,
    output logic              mem_store_o,
    output logic [STEP_W-1:0] step_o,
    output logic [ADJ_W-1:0]  mem_off_o,
    output logic              sp_we_o,
    output logic [ADJ_W-1:0]  sp_adj_o,
    output logic              a0_zero_o,
    output logic              ret_req_o,
    output logic              done_o
);
    state_e            st_q;
    variant_e          var_q;
    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W-1:0] step_q;
    logic [ADJ_W-1:0]  slot_q;
    logic [ADJ_W-1:0]  adj_q;
    logic [ADJ_W-1:0]  off_q;
    logic              illegal_q;
    logic              last_step;
    logic              is_push;

    // Final transfer detection and variant flag.
    always_comb begin
        last_step = (step_q == cnt_q - STEP_W'(1));
        is_push   = (var_q == VAR_PUSH);
    end

    // State, step counter and running offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            var_q     <= VAR_PUSH;
            cnt_q     <= '0;
            step_q    <= '0;
            slot_q    <= '0;
            adj_q     <= '0;
            off_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (legal_i) begin
                            st_q   <= ST_MEM;
                            var_q  <= variant_i;
                            cnt_q  <= count_i;
                            step_q <= '0;
                            slot_q <= slot_i;
                            adj_q  <= adj_i;
                            if (variant_i == VAR_PUSH)
                                off_q <= '0 - slot_i;
                            else
                                off_q <= adj_i - slot_i;
                        end else begin
                            illegal_q <= 1'b1;
                        end
                    end
                end
                ST_MEM: begin
                    if (mem_ready_i) begin
                        if (last_step) begin
                            st_q <= ST_SPW;
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                            off_q  <= off_q - slot_q;
                        end
                    end
                end
                ST_SPW: begin
                    if (var_q == VAR_POPRETZ)
                        st_q <= ST_ZERO;
                    else if (var_q == VAR_POPRET)
                        st_q <= ST_RET;
                    else
                        st_q <= ST_DONE;
                end
                ST_ZERO: st_q <= ST_RET;
                ST_RET:  st_q <= ST_DONE;
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Moore outputs decoded from the state.
    always_comb begin
        busy_o      = (st_q != ST_IDLE);
        illegal_o   = illegal_q;
        mem_valid_o = (st_q == ST_MEM);
        mem_store_o = mem_valid_o && is_push;
        step_o      = step_q;
        mem_off_o   = off_q;
        sp_we_o     = (st_q == ST_SPW);
        sp_adj_o    = is_push ? ('0 - adj_q) : adj_q;
        a0_zero_o   = (st_q == ST_ZERO);
        ret_req_o   = (st_q == ST_RET);
        done_o      = (st_q == ST_DONE);
    end
endmodule

// File: rtl/pp_expander.sv
// Module: pp_expander (top)
// Expands a compressed stack push/pop instruction into single-register
// load/store steps, one stack pointer update and the return tail actions.
// Assumes: the core holds off other work while busy_o is high.
module pp_expander
    import pp_pkg::*;
#(
    parameter int ALIGN_LG = 4,
    parameter int ADJ_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      instr_i,
    input  logic             xlen64_i,
    input  logic             mem_ready_i,
    output logic             busy_o,
    output logic             illegal_o,
    output logic             mem_valid_o,
    output logic             mem_store_o,
    output logic [4:0]       mem_reg_o,
    output logic [ADJ_W-1:0] mem_off_o,
    output logic             sp_we_o,
    output logic [ADJ_W-1:0] sp_adj_o,
    output logic             a0_zero_o,
    output logic             ret_req_o,
    output logic             done_o
);
    logic              dec_legal;
    variant_e          dec_var;
    logic [STEP_W-1:0] dec_count;
    logic [ADJ_W-1:0]  dec_slot;
    logic [ADJ_W-1:0]  dec_adj;
    logic [STEP_W-1:0] step;

    pp_decode #(.ALIGN_LG(ALIGN_LG), .ADJ_W(ADJ_W)) u_decode (
        .instr_i  (instr_i),
        .xlen64_i (xlen64_i),
        .legal_o  (dec_legal),
        .variant_o(dec_var),
        .count_o  (dec_count),
        .slot_o   (dec_slot),
        .adj_o    (dec_adj)
    );

    pp_seq #(.ADJ_W(ADJ_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .legal_i    (dec_legal),
        .variant_i  (dec_var),
        .count_i    (dec_count),
        .slot_i     (dec_slot),
        .adj_i      (dec_adj),
        .mem_ready_i(mem_ready_i),
        .busy_o     (busy_o),
        .illegal_o  (illegal_o),
        .mem_valid_o(mem_valid_o),
        .mem_store_o(mem_store_o),
        .step_o     (step),
        .mem_off_o  (mem_off_o),
        .sp_we_o    (sp_we_o),
        .sp_adj_o   (sp_adj_o),
        .a0_zero_o  (a0_zero_o),
        .ret_req_o  (ret_req_o),
        .done_o     (done_o)
    );

    pp_regmap u_regmap (
        .step_i(step),
        .reg_o (mem_reg_o)
    );
endmodule

// File: rtl/pp_expander_chk.sv
// Module: pp_expander_chk
// Port-level temporal checks for pp_expander, attached with bind.
module pp_expander_chk #(
    parameter int ADJ_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_ready_i,
    input logic             busy_o,
    input logic             illegal_o,
    input logic             mem_valid_o,
    input logic [4:0]       mem_reg_o,
    input logic [ADJ_W-1:0] mem_off_o,
    input logic             sp_we_o,
    input logic             a0_zero_o,
    input logic             ret_req_o,
    input logic             done_o
);
    // R2
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !busy_o && !mem_valid_o);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
            (mem_valid_o && $stable(mem_reg_o) && $stable(mem_off_o)));

    // R8
    sp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we_o |=> !sp_we_o);

    // R9
    zero_after_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a0_zero_o |-> $past(sp_we_o));

    // R9
    ret_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req_o |=> done_o);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_valid_o, sp_we_o, a0_zero_o, ret_req_o, done_o}));
endmodule

bind pp_expander pp_expander_chk #(.ADJ_W(ADJ_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ready_i(mem_ready_i),
    .busy_o     (busy_o),
    .illegal_o  (illegal_o),
    .mem_valid_o(mem_valid_o),
    .mem_reg_o  (mem_reg_o),
    .mem_off_o  (mem_off_o),
    .sp_we_o    (sp_we_o),
    .a0_zero_o  (a0_zero_o),
    .ret_req_o  (ret_req_o),
    .done_o     (done_o)
);

// File: tb/pp_expander_tb_top.sv
module pp_expander_tb_top;
    localparam int ADJ_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [15:0]      instr_i = '0;
    logic             xlen64_i = 1'b0;
    logic             mem_ready_i = 1'b0;
    logic             busy_o, illegal_o, mem_valid_o, mem_store_o;
    logic [4:0]       mem_reg_o;
    logic [ADJ_W-1:0] mem_off_o, sp_adj_o;
    logic             sp_we_o, a0_zero_o, ret_req_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pp_expander #(.ALIGN_LG(4), .ADJ_W(ADJ_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .xlen64_i(xlen64_i), .mem_ready_i(mem_ready_i), .busy_o(busy_o),
        .illegal_o(illegal_o), .mem_valid_o(mem_valid_o),
        .mem_store_o(mem_store_o), .mem_reg_o(mem_reg_o),
        .mem_off_o(mem_off_o), .sp_we_o(sp_we_o), .sp_adj_o(sp_adj_o),
        .a0_zero_o(a0_zero_o), .ret_req_o(ret_req_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int v, input int r, input int s);
        return {5'b10111, 2'(v), 1'b0, 4'(r), 2'(s), 2'b10};
    endfunction

    function automatic int exp_count(input int r);
        return (r == 15) ? 13 : r - 3;
    endfunction

    function automatic int exp_reg(input int i);
        if (i == 0) return 1;
        if (i == 1) return 8;
        if (i == 2) return 9;
        return 18 + (i - 3);
    endfunction

    function automatic int exp_mag(input int r, input int s, input bit x64);
        int b = x64 ? 8 : 4;
        int raw = exp_count(r) * b;
        return ((raw + 15) / 16) * 16 + s * 16;
    endfunction

    // Runs one instruction from an idle negedge to the idle negedge after it.
    task automatic run_case(input logic [15:0] ins, input bit x64);
        bit op_ok = (ins[1:0] == 2'b10) && (ins[15:11] == 5'b10111) && !ins[8];
        int r = int'(ins[7:4]);
        int s = int'(ins[3:2]);
        int v = int'(ins[10:9]);
        int b = x64 ? 8 : 4;
        int n, mag, step, guard, seen;
        bit rdy;
        start_i = 1'b1; instr_i = ins; xlen64_i = x64;
        @(negedge clk);
        start_i = 1'b0;
        if (!op_ok || r < 4) begin
            chk(illegal_o && !mem_valid_o && !busy_o, op_ok ? "R2" : "R1",
                "illegal pulse", int'(illegal_o), 1);
            @(negedge clk);
            chk(!illegal_o && !busy_o && !done_o, "R2", "illegal one cycle",
                int'(illegal_o), 0);
            return;
        end
        n = exp_count(r);
        mag = exp_mag(r, s, x64);
        step = 0; guard = 0; seen = -1;
        while (step < n && guard < 400) begin
            if (!mem_valid_o) begin
                chk(0, "R10", "request missing", 0, 1);
                break;
            end
            begin
                int eoff = (v == 0) ? -(step + 1) * b : mag - (step + 1) * b;
                string rq = (step == seen) ? "R7" : ((v == 0) ? "R5" : "R6");
                chk(int'(mem_reg_o) == exp_reg(step), (step == seen) ? "R7" : "R3",
                    "register", int'(mem_reg_o), exp_reg(step));
                chk(int'($signed(mem_off_o)) == eoff, rq, "offset",
                    int'($signed(mem_off_o)), eoff);
                chk(mem_store_o == (v == 0), rq, "direction",
                    int'(mem_store_o), int'(v == 0));
            end
            seen = step;
            rdy = ($urandom % 4) != 0;
            mem_ready_i = rdy;
            start_i = ($urandom % 3) == 0;   // R11: ignored while busy
            instr_i = mk($urandom % 4, 4 + $urandom % 12, $urandom % 4);
            @(negedge clk);
            if (rdy) step++;
            guard++;
        end
        mem_ready_i = 1'b0; start_i = 1'b0;
        chk(sp_we_o && !mem_valid_o, "R8", "stack write after last step",
            int'(sp_we_o), 1);
        chk(int'($signed(sp_adj_o)) == ((v == 0) ? -mag : mag), "R4", "adjust",
            int'($signed(sp_adj_o)), (v == 0) ? -mag : mag);
        @(negedge clk);
        if (v == 2) begin
            chk(a0_zero_o && !sp_we_o, "R9", "zero a0", int'(a0_zero_o), 1);
            @(negedge clk);
        end
        if (v >= 2) begin
            chk(ret_req_o && !a0_zero_o, "R9", "return request", int'(ret_req_o), 1);
            @(negedge clk);
        end
        chk(done_o && !ret_req_o && !sp_we_o, "R10", "done", int'(done_o), 1);
        @(negedge clk);
        chk(!done_o && !busy_o, "R10", "idle after done", int'(busy_o), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_valid_o && !sp_we_o && !done_o && !illegal_o,
            "R10", "reset state", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4 R5 R6: every list code, variant and width.
        for (int x = 0; x < 2; x++)
            for (int v = 0; v < 4; v++)
                for (int r = 4; r < 16; r++)
                    run_case(mk(v, r, (r + v) % 4), x[0]);
        // R2: reserved list codes.
        for (int r = 0; r < 4; r++) run_case(mk(r % 4, r, 1), 1'b0);
        // R1: corrupted opcode fields.
        run_case(mk(0, 8, 0) | 16'h0100, 1'b0);
        run_case(mk(1, 8, 0) ^ 16'h0001, 1'b1);
        run_case(mk(3, 8, 0) ^ 16'h4000, 1'b0);
        // R4: largest frame in both widths.
        run_case(mk(0, 15, 3), 1'b1);
        run_case(mk(1, 15, 3), 1'b0);
        // Random mix, including some corrupted words.
        for (int k = 0; k < 300; k++) begin
            logic [15:0] w = mk($urandom % 4, $urandom % 16, $urandom % 4);
            if (($urandom % 8) == 0) w = w ^ 16'(1 << ($urandom % 16));
            run_case(w, 1'($urandom % 2));
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule